// File: doc/BRIEF.md
# MSI Capture Interrupt Controller

This block sits beside the inbound write path of a host bridge and turns message-signalled interrupts into a level interrupt. Software programs a 64-bit capture address, which is held as two 32-bit halves, together with 32-bit enable and mask words. An inbound write is captured when all of these hold:

- its address equals the capture address,
- all four byte lanes are written, and
- the enable word is nonzero.

A captured write is absorbed, and the value it carries picks one bit of the 32-bit status word to set. Any other inbound request goes on to the downstream port unchanged.

The interrupt output is driven by a two-state machine. Its states are `IRQ_IDLE` and `IRQ_ACTIVE`. The RAISE transition (`IRQ_IDLE` to `IRQ_ACTIVE`) is taken on a captured write that leaves any status bit set whose mask bit is 0. The DROP transition (`IRQ_ACTIVE` to `IRQ_IDLE`) is taken on a software write to status that leaves the status word all zero. In every other cycle the state holds.

Software clears status by writing a pattern that is XORed into it. When a software status write and a captured write land in the same cycle, the XOR is applied first and the captured bit is ORed in after it.

Top module: `msicap_ctrl`

## Requirements
- R1: After reset, the capture address halves, enable, mask and status all read 0, and irq is 0.
- R2: Register offsets are 0x820 (address bits 31:0), 0x824 (address bits 63:32), 0x828 (enable), 0x82C (mask) and 0x830 (status). Writing one address half leaves the other half unchanged.
- R3: Enable and mask read back the value last written. Any other offset reads 0, and a write to it changes no register.
- R4: An inbound write with in_write=1, in_be=4'hF, in_addr equal to the capture address and a nonzero enable word is captured and is not forwarded (fwd_valid=0). If enable bit N is 1, where N is in_data, status bit N is set.
- R5: A captured write whose enable bit N is 0, or whose in_data is 32 or more, leaves status unchanged.
- R6: Reads, partial writes, writes to other addresses, and any request while enable is 0 are all forwarded, with fwd_* equal to in_* in the same cycle, and they leave status unchanged.
- R7: irq goes to 1 in the cycle after a captured write if, after that write's set, status AND NOT mask is nonzero. A write that sets only masked bits leaves irq at 0.
- R8: A software write to status XORs the written value into status. irq goes to 0 only after a status write that leaves status at 0. A mask write does not change irq.
- R9: When a status write and a captured write occur in the same cycle, the new status is (status XOR wdata) OR the captured bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset, used for both write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| in_valid | input | 1 | Inbound request valid |
| in_write | input | 1 | Inbound request is a write (1) or a read (0) |
| in_addr | input | 64 | Inbound request address |
| in_data | input | 32 | Inbound write data |
| in_be | input | 4 | Inbound byte enables |
| fwd_valid | output | 1 | Forwarded request valid |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | 64 | Forwarded address |
| fwd_data | output | 32 | Forwarded data |
| fwd_be | output | 4 | Forwarded byte enables |
| irq | output | 1 | Level interrupt, high in IRQ_ACTIVE |

## Verification
The hardest situation to reach from the ports is the one where a software status write and a captured message hit status in the same clock. The result depends on ordering only when the written pattern overlaps the captured bit. The bench therefore drives both interfaces in one cycle, using a pattern that covers the captured bit, so that the two possible orderings give different status values.

A second hard case is a RAISE caused by a message that sets no bit at all. To reach it, the bench first leaves bits pending while they are masked, then clears the mask, and then sends a message that carries an out-of-range vector.

// File: rtl/msicap_pkg.sv
package msicap_pkg;
    localparam int REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_TGT_LO = 12'h820;
    localparam logic [REG_AW-1:0] OFS_TGT_HI = 12'h824;
    localparam logic [REG_AW-1:0] OFS_ENABLE = 12'h828;
    localparam logic [REG_AW-1:0] OFS_MASK   = 12'h82C;
    localparam logic [REG_AW-1:0] OFS_STATUS = 12'h830;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/msicap_match.sv
module msicap_match
    import msicap_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 64
) (
    input  logic          in_valid,
    input  logic          in_write,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic [DW/8-1:0] in_be,
    input  logic [AW-1:0] tgt,
    input  logic [DW-1:0] enable,
    output logic          hit,
    output logic [DW-1:0] set_vec
);
    localparam int NVEC = DW;

    always_comb begin
        hit = in_valid && in_write && (&in_be) && (in_addr == tgt) && (|enable);
    end

    // One decoder slice per vector; the data value must equal the index exactly.
    for (genvar v = 0; v < NVEC; v++) begin : g_vec
        always_comb begin
            set_vec[v] = hit && (in_data == DW'(v)) && enable[v];
        end
    end
endmodule

// File: rtl/msicap_regs.sv
module msicap_regs
    import msicap_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 64,
    parameter int RAW = REG_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    input  logic [DW-1:0]  set_vec,
    output logic [AW-1:0]  tgt,
    output logic [DW-1:0]  enable,
    output logic [DW-1:0]  mask,
    output logic [DW-1:0]  status,
    output logic [DW-1:0]  status_next,
    output logic           sw_status_wr,
    output logic [DW-1:0]  reg_rdata
);
    localparam int HALVES = AW / DW;

    logic [DW-1:0] tgt_half [HALVES];

    always_comb begin
        sw_status_wr = reg_we && (reg_addr == OFS_STATUS);
        // Software XOR first, captured vector ORed afterwards.
        status_next  = (sw_status_wr ? (status ^ reg_wdata) : status) | set_vec;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam logic [RAW-1:0] OFS = OFS_TGT_LO + RAW'(4 * h);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tgt_half[h] <= '0;
            end else if (reg_we && reg_addr == OFS) begin
                tgt_half[h] <= reg_wdata;
            end
        end
        assign tgt[h*DW +: DW] = tgt_half[h];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            mask   <= '0;
            status <= '0;
        end else begin
            if (reg_we && reg_addr == OFS_ENABLE) enable <= reg_wdata;
            if (reg_we && reg_addr == OFS_MASK)   mask   <= reg_wdata;
            status <= status_next;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_TGT_LO: reg_rdata = tgt_half[0];
            OFS_TGT_HI: reg_rdata = tgt_half[HALVES-1];
            OFS_ENABLE: reg_rdata = enable;
            OFS_MASK:   reg_rdata = mask;
            OFS_STATUS: reg_rdata = status;
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/msicap_irq_fsm.sv
module msicap_irq_fsm
    import msicap_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic          sw_status_wr,
    input  logic [DW-1:0] status_next,
    input  logic [DW-1:0] mask,
    output logic          irq
);
    irq_state_e state_q, state_d;
    logic       raise_ev, drop_ev;

    always_comb begin
        raise_ev = hit && ((status_next & ~mask) != '0);
        drop_ev  = sw_status_wr && (status_next == '0);
        state_d  = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (raise_ev) state_d = IRQ_ACTIVE;
            IRQ_ACTIVE: if (drop_ev && !raise_ev) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IRQ_ACTIVE: irq = 1'b1;
            default:    irq = 1'b0;
        endcase
    end
endmodule

// File: rtl/msicap_ctrl.sv
module msicap_ctrl
    import msicap_pkg::*;
#(
    parameter int DW  = 32,
    parameter int AW  = 64,
    parameter int RAW = REG_AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RAW-1:0]  reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    input  logic            in_valid,
    input  logic            in_write,
    input  logic [AW-1:0]   in_addr,
    input  logic [DW-1:0]   in_data,
    input  logic [DW/8-1:0] in_be,
    output logic            fwd_valid,
    output logic            fwd_write,
    output logic [AW-1:0]   fwd_addr,
    output logic [DW-1:0]   fwd_data,
    output logic [DW/8-1:0] fwd_be,
    output logic            irq
);
    logic [AW-1:0] tgt;
    logic [DW-1:0] enable, mask, status_q, status_next, set_vec;
    logic          hit, sw_status_wr;

    msicap_match #(.DW(DW), .AW(AW)) u_match (
        .in_valid (in_valid),
        .in_write (in_write),
        .in_addr  (in_addr),
        .in_data  (in_data),
        .in_be    (in_be),
        .tgt      (tgt),
        .enable   (enable),
        .hit      (hit),
        .set_vec  (set_vec)
    );

    msicap_regs #(.DW(DW), .AW(AW), .RAW(RAW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .set_vec      (set_vec),
        .tgt          (tgt),
        .enable       (enable),
        .mask         (mask),
        .status       (status_q),
        .status_next  (status_next),
        .sw_status_wr (sw_status_wr),
        .reg_rdata    (reg_rdata)
    );

    msicap_irq_fsm #(.DW(DW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (hit),
        .sw_status_wr (sw_status_wr),
        .status_next  (status_next),
        .mask         (mask),
        .irq          (irq)
    );

    // Captured writes are absorbed; everything else goes downstream untouched.
    always_comb begin
        fwd_valid = in_valid && !hit;
        fwd_write = in_write;
        fwd_addr  = in_addr;
        fwd_data  = in_data;
        fwd_be    = in_be;
    end
endmodule

// File: rtl/msicap_ctrl_chk.sv
module msicap_ctrl_chk
    import msicap_pkg::*;
#(
    parameter int DW  = 32,
    parameter int RAW = REG_AW
) (
    input logic           clk,
    input logic           rst_n,
    input logic           reg_we,
    input logic [RAW-1:0] reg_addr,
    input logic           in_valid,
    input logic           in_write,
    input logic           fwd_valid,
    input logic           hit,
    input logic [DW-1:0]  status,
    input logic           irq
);
    logic sw_st;
    assign sw_st = reg_we && (reg_addr == OFS_STATUS);

    a_r6_read_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_write) |-> fwd_valid);

    a_r7_rise_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));

    a_r8_drop_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(sw_st) && status == '0));

    a_r4_status_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_st |=> (($past(status) & ~status) == '0));

    a_r6_status_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_st && !hit) |=> $stable(status));
endmodule

bind msicap_ctrl msicap_ctrl_chk #(.DW(DW), .RAW(RAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .in_valid  (in_valid),
    .in_write  (in_write),
    .fwd_valid (fwd_valid),
    .hit       (hit),
    .status    (status_q),
    .irq       (irq)
);

// File: tb/tb_msicap_ctrl.sv
module tb_msicap_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        in_valid, in_write;
    logic [63:0] in_addr;
    logic [31:0] in_data;
    logic [3:0]  in_be;
    logic        fwd_valid, fwd_write;
    logic [63:0] fwd_addr;
    logic [31:0] fwd_data;
    logic [3:0]  fwd_be;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [63:0] TGT = 64'h0000_0001_FEE0_0000;

    // {vector data, expected status, expected irq}; enable=0x0000FFFF, mask=0x000000F0
    localparam logic [64:0] VEC [6] = '{
        {32'd4,  32'h0000_0010, 1'b0},
        {32'd20, 32'h0000_0010, 1'b0},
        {32'd40, 32'h0000_0010, 1'b0},
        {32'd2,  32'h0000_0014, 1'b1},
        {32'd15, 32'h0000_8014, 1'b1},
        {32'd7,  32'h0000_8094, 1'b1}
    };

    always #10 clk = ~clk;

    msicap_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
        .in_write(in_write), .in_addr(in_addr), .in_data(in_data), .in_be(in_be),
        .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
        .fwd_data(fwd_data), .fwd_be(fwd_be), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        check(req, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    // Issue one inbound request; check forwarding in the same cycle.
    task automatic inb(input string req, input logic w, input logic [63:0] a,
                       input logic [31:0] d, input logic [3:0] be, input logic exp_fwd);
        @(negedge clk);
        in_valid = 1'b1; in_write = w; in_addr = a; in_data = d; in_be = be;
        #1;
        check(req, {63'h0, fwd_valid}, {63'h0, exp_fwd});
        if (exp_fwd) check(req, {fwd_addr ^ a}, 64'h0);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        in_valid = 1'b0; in_write = 1'b0; in_addr = '0; in_data = '0; in_be = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk("R1 tgt_lo", 12'h820, 32'h0);
        rd_chk("R1 tgt_hi", 12'h824, 32'h0);
        rd_chk("R1 enable", 12'h828, 32'h0);
        rd_chk("R1 mask",   12'h82C, 32'h0);
        rd_chk("R1 status", 12'h830, 32'h0);
        check("R1 irq", {63'h0, irq}, 64'h0);

        // R2 independent halves
        wr(12'h820, TGT[31:0]);
        rd_chk("R2 hi untouched", 12'h824, 32'h0);
        wr(12'h824, TGT[63:32]);
        rd_chk("R2 lo kept", 12'h820, TGT[31:0]);
        rd_chk("R2 hi written", 12'h824, TGT[63:32]);

        // R6 enable==0: matching write forwarded, no capture
        inb("R6 enable zero", 1'b1, TGT, 32'd3, 4'hF, 1'b1);
        rd_chk("R6 status after disabled", 12'h830, 32'h0);

        // R3 enable/mask readback, unmapped offset
        wr(12'h828, 32'h0000_FFFF);
        wr(12'h82C, 32'h0000_00F0);
        wr(12'h834, 32'hFFFF_FFFF);
        rd_chk("R3 unmapped", 12'h834, 32'h0);
        rd_chk("R3 enable", 12'h828, 32'h0000_FFFF);
        rd_chk("R3 mask", 12'h82C, 32'h0000_00F0);
        rd_chk("R3 status unaffected", 12'h830, 32'h0);

        // R6 non-captured requests
        inb("R6 read passes", 1'b0, TGT, 32'd3, 4'hF, 1'b1);
        inb("R6 partial write", 1'b1, TGT, 32'd3, 4'h7, 1'b1);
        inb("R6 other addr", 1'b1, TGT + 64'h4, 32'd3, 4'hF, 1'b1);
        rd_chk("R6 status unchanged", 12'h830, 32'h0);

        // R4 R5 R7 vector table
        for (int i = 0; i < 6; i++) begin
            inb("R4 captured not forwarded", 1'b1, TGT, VEC[i][64:33], 4'hF, 1'b0);
            rd_chk("R4 R5 status", 12'h830, VEC[i][32:1]);
            check("R7 irq", {63'h0, irq}, {63'h0, VEC[i][0]});
        end

        // R8 XOR clear, mask write does not drop irq
        wr(12'h830, 32'h0000_0004);
        rd_chk("R8 xor partial", 12'h830, 32'h0000_8090);
        check("R8 irq held", {63'h0, irq}, 64'h1);
        wr(12'h82C, 32'hFFFF_FFFF);
        check("R8 mask write keeps irq", {63'h0, irq}, 64'h1);
        wr(12'h830, 32'h0000_8090);
        rd_chk("R8 status zero", 12'h830, 32'h0);
        check("R8 irq dropped", {63'h0, irq}, 64'h0);

        // R9 simultaneous status write and capture
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h830; reg_wdata = 32'h3;
        in_valid = 1'b1; in_write = 1'b1; in_addr = TGT; in_data = 32'd1; in_be = 4'hF;
        @(negedge clk);
        reg_we = 1'b0; in_valid = 1'b0;
        rd_chk("R9 xor then set", 12'h830, 32'h3);
        check("R9 irq masked", {63'h0, irq}, 64'h0);

        // R7 capture with no bit set raises on pending unmasked status
        wr(12'h82C, 32'h0);
        check("R7 mask clear alone", {63'h0, irq}, 64'h0);
        inb("R7 out of range vector", 1'b1, TGT, 32'd40, 4'hF, 1'b0);
        check("R7 raise on capture", {63'h0, irq}, 64'h1);
        rd_chk("R5 out of range", 12'h830, 32'h3);
        wr(12'h830, 32'h3);
        check("R8 final drop", {63'h0, irq}, 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule